// File: doc/BRIEF.md
# UV-Erasable PROM Mode Model

A clocked, synthesizable model of a 4096 x 8 ultraviolet-erasable read-only memory. One input serves as both output enable and programming-voltage indication. The model decodes chip enable, that high-voltage flag and the address into five modes:

- read (and its twin, verify after programming)
- standby
- output-off
- program
- program-inhibit

In read mode the stored word is driven on a byte-wide bus. The bus is modelled as a data value plus a drive flag.

Programming can only clear bits: each accepted pulse stores the old word AND the bus value. Bits return to 1 only through a whole-array erase. The erase sweeps the array one word per cycle, and a busy flag covers the sweep.

A programming pulse is a chip-enable low pulse measured in clock cycles, given as cycles per millisecond. It must last between 45 and 55 ms. Pulses outside that window write nothing and raise an error flag.

Read timing is modelled in cycle counts:
- New data appears only once the address, chip enable and output enable have each been settled long enough.
- Until then the previous word is held on the bus.
- After output enable or chip enable is released, the bus keeps driving for a float delay, then stops.

All pins are plain levels. There is no handshake, and no back-pressure exists at any edge.

Top module: `eprom_mode_model`

## Requirements
- R1: With ce_n=0, oe_n=0 and vpp_hi=0 sampled at a clock edge, bus_en is 1 after that edge.
- R2: With ce_n=1 (standby) the bus stops being driven T_DF edges later whatever oe_n is, and stays undriven.
- R3: While vpp_hi=1 the bus is never newly driven (program and program-inhibit). With ce_n held at 1 no cell changes.
- R4: bus_data loads the addressed word only at an edge where chip enable has been sampled low for at least T_CE consecutive edges, output enable (with vpp_hi=0) for at least T_OE, and the address unchanged for at least T_ACC, counting that edge. Otherwise bus_data holds its value.
- R5: Once the R1 condition ends, bus_en stays 1 for T_DF-1 more edges and is 0 after the T_DF-th edge.
- R6: An accepted pulse stores old AND wr_data at the address presented at the edge where ce_n is seen rising. Bits never go from 0 to 1 by programming.
- R7: A pulse starts at an edge where ce_n=0, the previous sample was 1, and vpp_hi=1. Its length is the number of edges sampling ce_n=0. It is accepted when that length is in [45*CYC_PER_MS, 55*CYC_PER_MS], inclusive, and ce_n rises while vpp_hi=1.
- R8: A pulse ending outside that window writes nothing and sets pgm_err. pgm_err stays set until the next accepted pulse clears it.
- R9: If vpp_hi drops while a pulse is in progress, the pulse is abandoned: no write and no change to pgm_err. A chip enable held low without a rising edge never writes.
- R10: erase_req=1 at an edge while idle makes erase_busy 1 for exactly 2^ADDR_W cycles. Afterwards every word reads 0xFF. erase_req during a sweep is ignored.
- R11: A pulse that ends at an edge while erase_busy=1 writes nothing and sets pgm_err.
- R12: During and after reset bus_en=0 and pgm_err=0. A full erase sweep starts at reset, with erase_busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low; programming pulse input |
| oe_n | input | 1 | Output enable, active low; ignored while vpp_hi=1 |
| vpp_hi | input | 1 | Programming voltage present on the shared enable pin |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Bus value while programming |
| erase_req | input | 1 | Starts a whole-array erase |
| bus_data | output | DATA_W | Value on the data bus |
| bus_en | output | 1 | Bus driven (0 = high impedance) |
| erase_busy | output | 1 | Erase sweep in progress |
| pgm_err | output | 1 | Last finished pulse was rejected |

## Verification
The erase sweep and the end of a programming pulse can fall on the same clock edge. Both compete for the single array write port.

The bench provokes this by raising erase_req partway through an otherwise valid 50 ms pulse, so the pulse's rising edge lands while the sweep is running. It then judges three things: pgm_err rises at that edge, the target word reads 0xFF after the sweep, and the sweep length is unchanged.

A second erase request issued during the sweep checks that requests are not stacked.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_READ,
    MD_OUTOFF,
    MD_PROGRAM
  } eprom_mode_e;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        vpp_hi,
  output eprom_mode_e mode
);
  always_comb begin
    if (ce_n) mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    else if (vpp_hi) mode = MD_PROGRAM;
    else mode = oe_n ? MD_OUTOFF : MD_READ;
  end
endmodule

// File: rtl/eprom_pgm_pulse.sv
module eprom_pgm_pulse #(
  parameter int CYC_PER_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic vpp_hi,
  input  logic sweep_busy,
  output logic commit,
  output logic pgm_err
);
  localparam int MINC = 45 * CYC_PER_MS;
  localparam int MAXC = 55 * CYC_PER_MS;
  localparam int CW = $clog2(MAXC + 2);
  localparam logic [CW-1:0] MIN_W = CW'(MINC);
  localparam logic [CW-1:0] MAX_W = CW'(MAXC);

  logic          ce_q;
  logic          armed;
  logic [CW-1:0] cnt;
  logic          fall, rise, finish, in_win;

  assign fall   = !ce_n && ce_q && vpp_hi;
  assign rise   = ce_n && !ce_q;
  assign finish = vpp_hi && armed && rise;
  assign in_win = (cnt >= MIN_W) && (cnt <= MAX_W);
  assign commit = finish && in_win && !sweep_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      armed   <= 1'b0;
      cnt     <= '0;
      pgm_err <= 1'b0;
    end else begin
      ce_q <= ce_n;
      if (!vpp_hi) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (fall) begin
        armed <= 1'b1;
        cnt   <= CW'(1);
      end else if (armed && !ce_n) begin
        if (cnt <= MAX_W) cnt <= cnt + 1'b1;
      end else if (finish) begin
        armed   <= 1'b0;
        pgm_err <= !commit;
      end
    end
  end
endmodule

// File: rtl/eprom_erase_sweep.sv
module eprom_erase_sweep #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req,
  output logic              busy,
  output logic [ADDR_W-1:0] idx
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end else if (erase_req) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end
endmodule

// File: rtl/eprom_out_timing.sv
module eprom_out_timing #(
  parameter int ADDR_W = 12,
  parameter int T_ACC  = 8,
  parameter int T_CE   = 8,
  parameter int T_OE   = 3,
  parameter int T_DF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic              drive_en
);
  localparam int AGE_MAX = (T_ACC > T_CE) ? T_ACC : T_CE;
  localparam int AW = $clog2(AGE_MAX + 2);
  localparam logic [AW-1:0] SAT = AW'(AGE_MAX);
  localparam int FW = $clog2(T_DF + 2);

  logic [ADDR_W-1:0] addr_q;
  logic [AW-1:0]     a_age, c_age, o_age, a_nx, c_nx, o_nx;
  logic [FW-1:0]     fcnt, f_nx;
  logic              drive, en_nx;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] v);
    return (v >= SAT) ? SAT : v + 1'b1;
  endfunction

  assign a_nx  = (addr != addr_q) ? AW'(1) : bump(a_age);
  assign c_nx  = ce_n ? '0 : bump(c_age);
  assign o_nx  = (oe_n || vpp_hi) ? '0 : bump(o_age);
  assign load  = (a_nx >= AW'(T_ACC)) && (c_nx >= AW'(T_CE)) && (o_nx >= AW'(T_OE));
  assign drive = !ce_n && !oe_n && !vpp_hi;
  assign f_nx  = drive ? '0 : (drive_en ? fcnt + 1'b1 : '0);
  assign en_nx = drive || (drive_en && (f_nx < FW'(T_DF)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      a_age    <= '0;
      c_age    <= '0;
      o_age    <= '0;
      fcnt     <= '0;
      drive_en <= 1'b0;
    end else begin
      addr_q   <= addr;
      a_age    <= a_nx;
      c_age    <= c_nx;
      o_age    <= o_nx;
      fcnt     <= f_nx;
      drive_en <= en_nx;
    end
  end
endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_MS = 20,
  parameter int T_ACC      = 8,
  parameter int T_CE       = 8,
  parameter int T_OE       = 3,
  parameter int T_DF       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_req,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_en,
  output logic              erase_busy,
  output logic              pgm_err
);
  localparam int DEPTH = 1 << ADDR_W;

  eprom_mode_e       mode;
  logic              commit, load;
  logic [ADDR_W-1:0] sweep_idx;
  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;
  logic [DATA_W-1:0] mem [DEPTH];

  eprom_mode_dec u_dec (.ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .mode(mode));

  eprom_pgm_pulse #(.CYC_PER_MS(CYC_PER_MS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .vpp_hi(vpp_hi),
    .sweep_busy(erase_busy), .commit(commit), .pgm_err(pgm_err)
  );

  eprom_erase_sweep #(.ADDR_W(ADDR_W)) u_erase (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
    .busy(erase_busy), .idx(sweep_idx)
  );

  eprom_out_timing #(
    .ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE), .T_DF(T_DF)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .addr(addr), .load(load), .drive_en(bus_en)
  );

  assign we = erase_busy || (commit && (mode == MD_INHIBIT));
  assign wa = erase_busy ? sweep_idx : addr;
  assign wd = erase_busy ? '1 : (mem[addr] & wr_data);

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_data <= '0;
    else if (load) bus_data <= mem[addr];
  end
endmodule

// File: rtl/eprom_mode_checks.sv
module eprom_mode_checks #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_en,
  input logic              erase_busy,
  input logic              pgm_err
);
  localparam int BW = $clog2(DEPTH + 1) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (erase_busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_en) |-> $past(!ce_n && !oe_n && !vpp_hi));
  a_r3_no_drive_under_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vpp_hi) && $past(!bus_en) |-> !bus_en);
  a_r4_data_moves_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_data) |-> $past(!ce_n && !oe_n && !vpp_hi));
  a_r10_sweep_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (bcnt < BW'(DEPTH)));
  a_r10_sweep_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> (bcnt == BW'(DEPTH)));
  a_r8_err_on_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_err) |-> $past(ce_n && vpp_hi));
endmodule

bind eprom_mode_model eprom_mode_checks #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .bus_data(bus_data), .bus_en(bus_en), .erase_busy(erase_busy), .pgm_err(pgm_err)
);

// File: tb/tb_eprom_mode_model.sv
`timescale 1ns/1ps
module tb_eprom_mode_model;
  localparam int AW = 12, DW = 8, CPM = 2;
  localparam int TA = 6, TC = 5, TO = 2, TF = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, vpp_hi = 0, erase_req = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] bus_data;
  logic bus_en, erase_busy, pgm_err;
  int checks = 0, errors = 0;

  eprom_mode_model #(.ADDR_W(AW), .DATA_W(DW), .CYC_PER_MS(CPM),
    .T_ACC(TA), .T_CE(TC), .T_OE(TO), .T_DF(TF)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .addr(addr), .wr_data(wr_data), .erase_req(erase_req),
    .bus_data(bus_data), .bus_en(bus_en), .erase_busy(erase_busy), .pgm_err(pgm_err));

  always #4 clk = ~clk;

  // behavioural reference
  int m_mem [DEPTH];
  int m_busy, m_idx, m_ceq, m_armed, m_cnt, m_err;
  int m_addrq, m_aage, m_cage, m_oage, m_en, m_fcnt, m_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1; m_idx = 0; m_ceq = 1; m_armed = 0; m_cnt = 0; m_err = 0;
      m_addrq = 0; m_aage = 0; m_cage = 0; m_oage = 0; m_en = 0; m_fcnt = 0; m_dout = 0;
    end else begin
      int rd_word, busy_pre, drv;
      rd_word = m_mem[addr];
      busy_pre = m_busy;
      // read timing
      m_aage = (int'(addr) != m_addrq) ? 1 : m_aage + 1;
      m_addrq = int'(addr);
      m_cage = ce_n ? 0 : m_cage + 1;
      m_oage = (oe_n || vpp_hi) ? 0 : m_oage + 1;
      if (m_aage >= TA && m_cage >= TC && m_oage >= TO) m_dout = rd_word;
      drv = (!ce_n && !oe_n && !vpp_hi);
      if (drv) begin m_en = 1; m_fcnt = 0; end
      else if (m_en) begin m_fcnt++; if (m_fcnt >= TF) m_en = 0; end
      // programming pulse
      if (!vpp_hi) begin m_armed = 0; m_cnt = 0; end
      else if (!ce_n && m_ceq) begin m_armed = 1; m_cnt = 1; end
      else if (m_armed && !ce_n) m_cnt++;
      else if (m_armed && ce_n && !m_ceq) begin
        m_armed = 0;
        if (m_cnt >= 45*CPM && m_cnt <= 55*CPM && !busy_pre) begin
          m_mem[addr] = rd_word & int'(wr_data); m_err = 0;
        end else m_err = 1;
      end
      m_ceq = ce_n;
      // erase
      if (m_busy) begin
        m_mem[m_idx] = 8'hFF; m_idx++;
        if (m_idx == DEPTH) m_busy = 0;
      end else if (erase_req) begin m_busy = 1; m_idx = 0; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n) begin
    chk("R5 bus_en", bus_en, m_en);
    if (m_en) chk("R4 bus_data", bus_data, m_dout);
    chk("R10 erase_busy", erase_busy, m_busy);
    chk("R8 pgm_err", pgm_err, m_err);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int a, input int d, input int n);
    vpp_hi = 1; addr = AW'(a); wr_data = DW'(d); ce_n = 1; oe_n = 1;
    wait_n(2);
    ce_n = 0; wait_n(n);
    ce_n = 1; wait_n(2);
    vpp_hi = 0; wait_n(2);
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a); ce_n = 0; oe_n = 0; vpp_hi = 0;
    wait_n(10);
    v = int'(bus_data);
    ce_n = 1; oe_n = 1; wait_n(4);
  endtask

  task automatic wait_idle();
    while (erase_busy) @(negedge clk);
  endtask

  initial begin
    int v, cyc;
    wait_n(3);
    chk("R12 reset bus_en", bus_en, 0);
    chk("R12 reset pgm_err", pgm_err, 0);
    chk("R12 reset busy", erase_busy, 1);
    rst_n = 1;
    cyc = 0;
    @(negedge clk);
    while (erase_busy) begin cyc++; @(negedge clk); end
    chk("R12 R10 sweep length", cyc + 1, DEPTH);
    rd(5, v); chk("R1 read erased", v, 8'hFF);
    pulse(5, 8'hA5, 50*CPM); chk("R8 ok pulse", pgm_err, 0);
    rd(5, v); chk("R6 verify first", v, 8'hA5);
    pulse(5, 8'h5A, 50*CPM);
    rd(5, v); chk("R6 AND only", v, 8'h00);
    pulse(7, 8'h0F, 45*CPM - 1); chk("R8 short err", pgm_err, 1);
    rd(7, v); chk("R8 short no write", v, 8'hFF);
    pulse(7, 8'h0F, 45*CPM); chk("R7 min accepted", pgm_err, 0);
    rd(7, v); chk("R7 min write", v, 8'h0F);
    pulse(8, 8'hF0, 55*CPM + 1); chk("R8 long err", pgm_err, 1);
    rd(8, v); chk("R8 long no write", v, 8'hFF);
    pulse(8, 8'hF0, 55*CPM); chk("R7 max accepted", pgm_err, 0);
    rd(8, v); chk("R7 max write", v, 8'hF0);
    // R3 inhibit, oe_n low too
    addr = 9; wr_data = 0; vpp_hi = 1; oe_n = 0; ce_n = 1; wait_n(120);
    chk("R3 inhibit bus", bus_en, 0);
    vpp_hi = 0; oe_n = 1; wait_n(3);
    rd(9, v); chk("R3 inhibit no write", v, 8'hFF);
    // R3 program mode with oe low does not drive
    vpp_hi = 1; oe_n = 0; wait_n(2); ce_n = 0; wait_n(10);
    chk("R3 program no drive", bus_en, 0);
    // R9 vpp drops mid pulse, then static low
    addr = 10; wait_n(90); vpp_hi = 0; wait_n(3); oe_n = 1; wait_n(40);
    ce_n = 1; wait_n(3);
    chk("R9 err unchanged", pgm_err, 0);
    rd(10, v); chk("R9 no write", v, 8'hFF);
    // R2 standby ignores oe
    ce_n = 1; oe_n = 0; wait_n(20);
    chk("R2 standby float", bus_en, 0);
    oe_n = 1;
    // R5 float delay and R4 address hold
    addr = 5; ce_n = 0; oe_n = 0; wait_n(10);
    chk("R4 word 5", bus_data, 8'h00);
    addr = 7; wait_n(TA - 1);
    chk("R4 held before tacc", bus_data, 8'h00);
    wait_n(1);
    chk("R4 new after tacc", bus_data, 8'h0F);
    oe_n = 1; addr = 8; wait_n(1);
    chk("R5 still driven", bus_en, 1);
    wait_n(TF - 1);
    chk("R5 floated", bus_en, 0);
    wait_n(10); oe_n = 0; wait_n(1);
    chk("R1 driven after oe", bus_en, 1);
    chk("R4 held before toe", bus_data, 8'h0F);
    wait_n(TO - 1);
    chk("R4 new after toe", bus_data, 8'hF0);
    ce_n = 1; oe_n = 1; wait_n(5);
    // R11 erase collides with pulse end
    vpp_hi = 1; addr = 11; wr_data = 0; wait_n(2); ce_n = 0;
    wait_n(10); erase_req = 1; wait_n(1); erase_req = 0;
    wait_n(50*CPM - 11); ce_n = 1; wait_n(1);
    chk("R11 busy during end", erase_busy, 1);
    chk("R11 err", pgm_err, 1);
    wait_n(2); vpp_hi = 0;
    erase_req = 1; wait_n(1); erase_req = 0;  // R10 ignored while busy
    wait_idle();
    rd(11, v); chk("R11 no write", v, 8'hFF);
    rd(5, v); chk("R10 erase restores", v, 8'hFF);
    wait_n(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule